// File: doc/BRIEF.md
# Compact Serial Port with Register Bus

This block is a small asynchronous serial port that sits behind a word-addressed register bus. Software pushes bytes into an eight-entry transmit queue by writing the data register. The transmitter sends each byte as one frame: a low start bit, seven or eight data bits with the least significant bit first, and one high stop bit. There is no parity. The receiver rebuilds incoming frames into an eight-entry receive queue, and software drains that queue by reading the same data register.

Both directions take their bit time from the system clock through a 16-bit divisor, with eight ticks per bit. Two interrupt causes can be masked, and they drive a single request line. Software sets the request-to-send output, can read the clear-to-send input, and can hold the line in a break condition. The first eight register indices follow a familiar 16550-like layout. Indices 8 to 10 hold the enables, a compact status word and the divisor.

Top module: `lite_uart`

## Requirements
- R1: A frame on `txd_o` is one low start bit, the data bits LSB first, then one high stop bit. Line control (index 3) bit 0 set selects 8 data bits, and clear selects 7 (field value 3 or 0 in bits 1:0). The line idles high.
- R2: Every serial bit lasts 8 × (D + 1) clock cycles, where D is the 16-bit divisor at index 10. Its reset value is the parameter `BAUD_RESET`, which defaults to 0.
- R3: Each queue holds 8 bytes. A write to index 0 while the transmit queue is full is dropped. Index 9 reads bit 0 = receive byte available and bit 1 = transmit space available.
- R4: A frame that completes while the receive queue is full is discarded and sets the overrun flag (line status bit 1). A read of line status (index 5) clears that flag afterwards.
- R5: Line status reads bit 0 = receive data ready, bit 5 = transmit queue not full, and bit 6 = transmit queue empty with the shifter idle. After reset it reads 0x60.
- R6: Interrupt enable (index 1) bit 0 arms the receive cause and bit 1 arms the transmit cause. `irq_o` can be high only while bits 2 and 3 are both set.
- R7: Interrupt identify (index 2) reads bit 0 = no enabled cause pending, bit 2 = receive data present, and bit 1 = transmit queue empty. Only one of bits 1 and 2 is set at a time, and receive wins.
- R8: Writing index 2 with bit 1 set empties the receive queue. Writing it with bit 2 set empties the transmit queue.
- R9: Modem control (index 4) bit 1 drives `rts_o` from the next cycle on. Modem status (index 6) bit 5 shows `cts_i` after a two-stage synchronizer.
- R10: Line control bit 6 holds `txd_o` low for as long as it is set.
- R11: Index 8 bit 0 enables the receiver and bit 1 enables the transmitter. Both are set at reset. A disabled receiver takes no frames, and a disabled transmitter starts no frames.
- R12: The receiver confirms a start bit 4 ticks after the falling edge. A low pulse shorter than half a bit produces no byte.
- R13: Bits with no function read as 0 and ignore writes. Indices 11 to 15 read 0. Reading index 0 pops the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 4 | Register word index |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (has side effects) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid while reg_rd_i is high |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rts_o | output | 1 | Request-to-send, software controlled |
| cts_i | input | 1 | Clear-to-send, readable |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a receive overrun. It needs nine complete frames to arrive while software reads nothing, and then two line-status reads in a row to show the flag set and then cleared. The bench drives nine serial frames back to back, queuing only the first eight as expected. It then reads status twice and drains the queue. A short start-bit glitch is also driven, followed by a valid frame, to show that the receiver rejects the first and still locks onto the second.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
    localparam logic [3:0] IDX_DATA  = 4'd0;
    localparam logic [3:0] IDX_IEN   = 4'd1;
    localparam logic [3:0] IDX_IID   = 4'd2;
    localparam logic [3:0] IDX_LCTL  = 4'd3;
    localparam logic [3:0] IDX_MCTL  = 4'd4;
    localparam logic [3:0] IDX_LSTAT = 4'd5;
    localparam logic [3:0] IDX_MSTAT = 4'd6;
    localparam logic [3:0] IDX_SCR   = 4'd7;
    localparam logic [3:0] IDX_XCTL  = 4'd8;
    localparam logic [3:0] IDX_XSTAT = 4'd9;
    localparam logic [3:0] IDX_BAUD  = 4'd10;

    localparam int TICKS_PER_BIT = 8;
    localparam int START_CONFIRM = 4;
    localparam int BUS_W         = 16;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/lite_uart_fifo.sv
module lite_uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         clr_i,
    input  logic                         push_i,
    input  logic [W-1:0]                 data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 data_o,
    output logic                         empty_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (q.cnt == CW'(DEPTH));
    assign empty_o = (q.cnt == '0);
    assign count_o = q.cnt;
    assign data_o  = q.mem[q.rd];

    always_comb begin
        d       = q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (clr_i) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wr] = data_i;
                d.wr        = step(q.wr);
            end
            if (do_pop) begin
                d.rd = step(q.rd);
            end
            if (do_push && !do_pop) begin
                d.cnt = q.cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lite_uart_tick.sv
module lite_uart_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q, cnt_d;

    assign tick_o = (cnt_q >= div_i);

    always_comb begin
        if (restart_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lite_uart_tx.sv
module lite_uart_tx
    import lite_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             wide_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             empty_i,
    input  logic [7:0]       data_i,
    output logic             pop_o,
    output logic             busy_o,
    output logic             line_o
);
    typedef struct packed {
        logic       busy;
        logic [9:0] shift;
        logic [3:0] bits;
        logic [2:0] ticks;
    } tx_st_t;

    tx_st_t q, d;
    logic   restart, tick;

    lite_uart_tick #(.DIV_W(DIV_W)) tick_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(restart),
        .div_i    (div_i),
        .tick_o   (tick)
    );

    always_comb begin
        d       = q;
        pop_o   = 1'b0;
        restart = 1'b0;
        if (!q.busy) begin
            if (en_i && !empty_i) begin
                pop_o   = 1'b1;
                restart = 1'b1;
                d.busy  = 1'b1;
                d.shift = {1'b1, (wide_i ? data_i[7] : 1'b1), data_i[6:0], 1'b0};
                d.bits  = wide_i ? 4'd10 : 4'd9;
                d.ticks = '0;
            end
        end else if (tick) begin
            if (q.ticks == 3'(TICKS_PER_BIT - 1)) begin
                d.ticks = '0;
                d.shift = {1'b1, q.shift[9:1]};
                d.bits  = q.bits - 1'b1;
                if (q.bits == 4'd1) begin
                    d.busy = 1'b0;
                end
            end else begin
                d.ticks = q.ticks + 1'b1;
            end
        end
    end

    assign busy_o = q.busy;
    assign line_o = q.busy ? q.shift[0] : 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lite_uart_rx.sv
module lite_uart_rx
    import lite_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             wide_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rxd_i,
    output logic             valid_o,
    output logic [7:0]       data_o
);
    typedef struct packed {
        logic [1:0] sync;
        rx_state_e  st;
        logic [2:0] ticks;
        logic [2:0] idx;
        logic [7:0] data;
    } rx_st_t;

    rx_st_t q, d;
    logic   restart, tick, line, done;

    lite_uart_tick #(.DIV_W(DIV_W)) tick_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(restart),
        .div_i    (div_i),
        .tick_o   (tick)
    );

    assign line = q.sync[1];

    always_comb begin
        d       = q;
        restart = 1'b0;
        done    = 1'b0;
        d.sync  = {q.sync[0], rxd_i};
        case (q.st)
            RX_IDLE: begin
                if (!line) begin
                    d.st    = RX_START;
                    d.ticks = '0;
                    restart = 1'b1;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.ticks == 3'(START_CONFIRM - 1)) begin
                        d.ticks = '0;
                        d.idx   = '0;
                        d.data  = '0;
                        d.st    = line ? RX_IDLE : RX_DATA;
                    end else begin
                        d.ticks = q.ticks + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (q.ticks == 3'(TICKS_PER_BIT - 1)) begin
                        d.ticks       = '0;
                        d.data[q.idx] = line;
                        if (q.idx == (wide_i ? 3'd7 : 3'd6)) begin
                            d.st = RX_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.ticks = q.ticks + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (q.ticks == 3'(TICKS_PER_BIT - 1)) begin
                        done = 1'b1;
                        d.st = RX_IDLE;
                    end else begin
                        d.ticks = q.ticks + 1'b1;
                    end
                end
            end
            default: d.st = RX_IDLE;
        endcase
        if (!en_i) begin
            d.st    = RX_IDLE;
            restart = 1'b0;
        end
    end

    assign valid_o = done && en_i;
    assign data_o  = q.data;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.sync <= 2'b11;
            q.st   <= RX_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lite_uart.sv
module lite_uart
    import lite_uart_pkg::*;
#(
    parameter int                  FIFO_DEPTH = 8,
    parameter int                  BAUD_W     = 16,
    parameter logic [BAUD_W-1:0]   BAUD_RESET = '0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [3:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    output logic        txd_o,
    input  logic        rxd_i,
    output logic        rts_o,
    input  logic        cts_i,
    output logic        irq_o
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [3:0]        ien;
        logic [1:0]        wlen;
        logic              brk;
        logic              rts;
        logic [7:0]        scr;
        logic              rx_en;
        logic              tx_en;
        logic [BAUD_W-1:0] baud;
        logic              ovr;
        logic [1:0]        cts_sync;
    } regs_t;

    regs_t q, d;

    logic          rx_pop, tx_push, rx_clr, tx_clr;
    logic          rx_empty, rx_full, tx_empty, tx_full;
    logic [7:0]    rx_head, tx_head;
    logic [CW-1:0] rx_cnt_w, tx_cnt_w;
    logic          rx_valid, rx_push, rx_drop_w;
    logic [7:0]    rx_byte;
    logic          tx_pop, tx_busy_w, tx_line;
    logic          gate, rx_cause, tx_cause, wide;
    logic [BUS_W-1:0] rdata;
    logic [3:0]    ien_w;
    logic          brk_w, ovr_w;

    assign wide      = q.wlen[0];
    assign rx_push   = rx_valid && !rx_full;
    assign rx_drop_w = rx_valid && rx_full;

    lite_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (rx_clr),
        .push_i (rx_push),
        .data_i (rx_byte),
        .pop_i  (rx_pop),
        .data_o (rx_head),
        .empty_o(rx_empty),
        .full_o (rx_full),
        .count_o(rx_cnt_w)
    );

    lite_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tx_clr),
        .push_i (tx_push),
        .data_i (reg_wdata_i[7:0]),
        .pop_i  (tx_pop),
        .data_o (tx_head),
        .empty_o(tx_empty),
        .full_o (tx_full),
        .count_o(tx_cnt_w)
    );

    lite_uart_tx #(.DIV_W(BAUD_W)) tx_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (q.tx_en),
        .wide_i (wide),
        .div_i  (q.baud),
        .empty_i(tx_empty),
        .data_i (tx_head),
        .pop_o  (tx_pop),
        .busy_o (tx_busy_w),
        .line_o (tx_line)
    );

    lite_uart_rx #(.DIV_W(BAUD_W)) rx_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (q.rx_en),
        .wide_i (wide),
        .div_i  (q.baud),
        .rxd_i  (rxd_i),
        .valid_o(rx_valid),
        .data_o (rx_byte)
    );

    always_comb begin
        d          = q;
        rx_pop     = 1'b0;
        tx_push    = 1'b0;
        rx_clr     = 1'b0;
        tx_clr     = 1'b0;
        rdata      = '0;
        d.cts_sync = {q.cts_sync[0], cts_i};
        gate       = q.ien[3] & q.ien[2];
        rx_cause   = gate & q.ien[0] & ~rx_empty;
        tx_cause   = gate & q.ien[1] & tx_empty;

        if (reg_rd_i) begin
            case (reg_addr_i)
                IDX_DATA: begin
                    rdata[7:0] = rx_empty ? 8'h00 : rx_head;
                    rx_pop     = 1'b1;
                end
                IDX_IEN:   rdata[3:0] = q.ien;
                IDX_IID:   rdata[2:0] = {rx_cause, tx_cause & ~rx_cause, ~(rx_cause | tx_cause)};
                IDX_LCTL: begin
                    rdata[1:0] = q.wlen;
                    rdata[6]   = q.brk;
                end
                IDX_MCTL:  rdata[1] = q.rts;
                IDX_LSTAT: begin
                    rdata[0] = ~rx_empty;
                    rdata[1] = q.ovr;
                    rdata[5] = ~tx_full;
                    rdata[6] = tx_empty & ~tx_busy_w;
                end
                IDX_MSTAT: rdata[5]   = q.cts_sync[1];
                IDX_SCR:   rdata[7:0] = q.scr;
                IDX_XCTL:  rdata[1:0] = {q.tx_en, q.rx_en};
                IDX_XSTAT: rdata[1:0] = {~tx_full, ~rx_empty};
                IDX_BAUD:  rdata[BAUD_W-1:0] = q.baud;
                default:   rdata = '0;
            endcase
        end

        if (reg_wr_i) begin
            case (reg_addr_i)
                IDX_DATA: tx_push = 1'b1;
                IDX_IEN:  d.ien   = reg_wdata_i[3:0];
                IDX_IID: begin
                    rx_clr = reg_wdata_i[1];
                    tx_clr = reg_wdata_i[2];
                end
                IDX_LCTL: begin
                    d.wlen = reg_wdata_i[1:0];
                    d.brk  = reg_wdata_i[6];
                end
                IDX_MCTL: d.rts = reg_wdata_i[1];
                IDX_SCR:  d.scr = reg_wdata_i[7:0];
                IDX_XCTL: begin
                    d.rx_en = reg_wdata_i[0];
                    d.tx_en = reg_wdata_i[1];
                end
                IDX_BAUD: d.baud = reg_wdata_i[BAUD_W-1:0];
                default: ;
            endcase
        end

        d.ovr = (q.ovr & ~(reg_rd_i && (reg_addr_i == IDX_LSTAT))) | rx_drop_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q          <= '0;
            q.wlen     <= 2'b11;
            q.rx_en    <= 1'b1;
            q.tx_en    <= 1'b1;
            q.baud     <= BAUD_RESET;
        end else begin
            q <= d;
        end
    end

    assign ien_w       = q.ien;
    assign brk_w       = q.brk;
    assign ovr_w       = q.ovr;
    assign reg_rdata_o = rdata;
    assign txd_o       = q.brk ? 1'b0 : tx_line;
    assign rts_o       = q.rts;
    assign irq_o       = rx_cause | tx_cause;
endmodule

// File: rtl/lite_uart_chk.sv
module lite_uart_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [3:0]                 reg_addr_i,
    input logic                       reg_wr_i,
    input logic                       reg_rd_i,
    input logic [15:0]                reg_wdata_i,
    input logic                       txd_o,
    input logic                       rts_o,
    input logic                       irq_o,
    input logic [3:0]                 ien,
    input logic                       brk,
    input logic                       tx_busy,
    input logic                       ovr,
    input logic                       rx_drop,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt
);
    assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ien[3] && ien[2]));

    assert_idle_mark_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tx_busy && !brk) |-> txd_o);

    assert_break_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 4'd3 && reg_wdata_i[6]) |=> !txd_o);

    assert_fifo_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_cnt <= DEPTH) && (tx_cnt <= DEPTH));

    assert_rts_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 4'd4) |=> (rts_o == $past(reg_wdata_i[1])));

    assert_ovr_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && reg_addr_i == 4'd5 && !rx_drop) |=> !ovr);
endmodule

bind lite_uart lite_uart_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_wdata_i(reg_wdata_i),
    .txd_o      (txd_o),
    .rts_o      (rts_o),
    .irq_o      (irq_o),
    .ien        (ien_w),
    .brk        (brk_w),
    .tx_busy    (tx_busy_w),
    .ovr        (ovr_w),
    .rx_drop    (rx_drop_w),
    .rx_cnt     (rx_cnt_w),
    .tx_cnt     (tx_cnt_w)
);

// File: tb/lite_uart_tb_top.sv
module lite_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        wr, rd;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        txd;
    logic        rxd = 1'b1;
    logic        rts;
    logic        cts = 1'b0;
    logic        irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;
    bit  mon_off  = 0;
    int  bit_clks = 8;

    logic [8:0] txq[$];
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    lite_uart dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .reg_addr_i (addr),
        .reg_wr_i   (wr),
        .reg_rd_i   (rd),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .txd_o      (txd),
        .rxd_i      (rxd),
        .rts_o      (rts),
        .cts_i      (cts),
        .irq_o      (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [15:0] exp, input string req);
        logic [15:0] v;
        rd_reg(a, v);
        check(req, v, exp);
    endtask

    task automatic tx_send(input logic [7:0] b, input bit wide);
        txq.push_back({wide, b});
        wr_reg(4'd0, {8'h00, b});
    endtask

    task automatic rx_drive(input logic [7:0] b, input bit wide, input bit keep);
        if (keep) rxq.push_back(wide ? b : {1'b0, b[6:0]});
        rxd = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < (wide ? 8 : 7); i++) begin
            rxd = b[i];
            repeat (bit_clks) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bit_clks) @(negedge clk);
    endtask

    task automatic rx_read(input string req);
        logic [15:0] v;
        logic [7:0]  e;
        rd_reg(4'd0, v);
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
        check(req, v, {8'h00, e});
    endtask

    task automatic wait_tx_idle();
        while (txq.size() != 0) @(negedge clk);
        repeat (bit_clks * 2) @(negedge clk);
    endtask

    // Scoreboard monitor: decodes frames on txd and compares with queued items
    initial begin
        forever begin
            @(negedge clk);
            if (!mon_off && rst_n === 1'b1 && txd === 1'b0) begin
                logic [8:0] it;
                logic [7:0] got;
                logic       stop;
                int         nb;
                repeat (bit_clks / 2) @(negedge clk);
                if (txq.size() == 0) begin
                    check("R3 R8 unexpected tx frame", 32'd1, 32'd0);
                    it = 9'h100;
                end else begin
                    it = txq[0];
                end
                nb  = it[8] ? 8 : 7;
                got = 8'h00;
                for (int i = 0; i < nb; i++) begin
                    repeat (bit_clks) @(negedge clk);
                    got[i] = txd;
                end
                repeat (bit_clks) @(negedge clk);
                stop = txd;
                if (txq.size() != 0) void'(txq.pop_front());
                check("R1 R2 tx frame data", got, it[8] ? it[7:0] : {1'b0, it[6:0]});
                check("R1 tx stop bit", stop, 1'b1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R1 idle line after reset", txd, 1'b1);
        check("R6 irq low after reset", irq, 1'b0);
        check("R9 rts low after reset", rts, 1'b0);
        expect_reg(4'd5, 16'h0060, "R5 line status reset");
        expect_reg(4'd2, 16'h0001, "R7 identify reset");
        expect_reg(4'd8, 16'h0003, "R11 enables reset");
        expect_reg(4'd10, 16'h0000, "R2 divisor reset");

        wr_reg(4'd10, 16'd1);
        bit_clks = 16;
        expect_reg(4'd10, 16'h0001, "R2 divisor readback");

        // 8-bit transmit
        tx_send(8'hA5, 1'b1);
        tx_send(8'h3C, 1'b1);
        tx_send(8'hFF, 1'b1);
        tx_send(8'h00, 1'b1);
        wait_tx_idle();
        expect_reg(4'd5, 16'h0060, "R5 idle after transmit");

        // 7-bit both ways
        wr_reg(4'd3, 16'h0000);
        tx_send(8'hC5, 1'b0);
        rx_drive(8'hDA, 1'b0, 1'b1);
        wait_tx_idle();
        rx_read("R1 seven-bit receive");
        wr_reg(4'd3, 16'h0003);

        // Slower divisor
        wr_reg(4'd10, 16'd3);
        bit_clks = 32;
        tx_send(8'h96, 1'b1);
        rx_drive(8'h69, 1'b1, 1'b1);
        wait_tx_idle();
        rx_read("R2 receive at divisor 3");
        wr_reg(4'd10, 16'd1);
        bit_clks = 16;

        // Transmit queue full
        wr_reg(4'd8, 16'h0001);
        for (int i = 0; i < 8; i++) tx_send(8'h40 + 8'(i), 1'b1);
        wr_reg(4'd0, 16'h00EE);
        expect_reg(4'd9, 16'h0000, "R3 no space when full");
        expect_reg(4'd5, 16'h0000, "R5 full queue status");
        wr_reg(4'd8, 16'h0003);
        wait_tx_idle();
        repeat (200) @(negedge clk);
        check("R3 dropped push sent nothing", txq.size(), 0);
        expect_reg(4'd5, 16'h0060, "R5 idle after drain");

        // Basic receive
        rx_drive(8'h81, 1'b1, 1'b1);
        expect_reg(4'd5, 16'h0061, "R5 data ready");
        expect_reg(4'd9, 16'h0003, "R3 compact status");
        rx_read("R13 data read pops");
        expect_reg(4'd5, 16'h0060, "R13 queue empty after pop");

        // Overrun
        for (int i = 0; i < 9; i++) rx_drive(8'h10 + 8'(i), 1'b1, i < 8);
        expect_reg(4'd5, 16'h0063, "R4 overrun set");
        expect_reg(4'd5, 16'h0061, "R4 overrun cleared by read");
        for (int i = 0; i < 8; i++) rx_read("R4 kept bytes");
        expect_reg(4'd5, 16'h0060, "R4 queue drained");

        // Receiver disabled
        wr_reg(4'd8, 16'h0002);
        rx_drive(8'h55, 1'b1, 1'b0);
        expect_reg(4'd5, 16'h0060, "R11 disabled receiver");
        wr_reg(4'd8, 16'h0003);

        // Glitch rejection
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        expect_reg(4'd5, 16'h0060, "R12 glitch rejected");
        rx_drive(8'hC3, 1'b1, 1'b1);
        rx_read("R12 frame after glitch");

        // Interrupts
        wr_reg(4'd1, 16'h000F);
        check("R6 irq tx cause", irq, 1'b1);
        expect_reg(4'd2, 16'h0002, "R7 tx cause");
        rx_drive(8'h3C, 1'b1, 1'b1);
        expect_reg(4'd2, 16'h0004, "R7 receive priority");
        check("R6 irq rx cause", irq, 1'b1);
        rx_read("R7 data under irq");
        expect_reg(4'd2, 16'h0002, "R7 tx after pop");
        wr_reg(4'd1, 16'h0003);
        check("R6 irq gated off", irq, 1'b0);
        expect_reg(4'd2, 16'h0001, "R6 identify gated");
        wr_reg(4'd1, 16'h000D);
        check("R6 tx cause masked", irq, 1'b0);
        rx_drive(8'h11, 1'b1, 1'b1);
        check("R6 rx cause armed", irq, 1'b1);
        expect_reg(4'd2, 16'h0004, "R7 rx only");
        rx_read("R6 data");
        wr_reg(4'd1, 16'h0000);

        // Queue clearing
        rx_drive(8'h77, 1'b1, 1'b0);
        expect_reg(4'd5, 16'h0061, "R8 byte waiting");
        wr_reg(4'd2, 16'h0002);
        expect_reg(4'd5, 16'h0060, "R8 receive queue cleared");
        wr_reg(4'd8, 16'h0001);
        wr_reg(4'd0, 16'h0012);
        wr_reg(4'd0, 16'h0034);
        expect_reg(4'd5, 16'h0020, "R8 transmit queue loaded");
        wr_reg(4'd2, 16'h0004);
        expect_reg(4'd5, 16'h0060, "R8 transmit queue cleared");
        wr_reg(4'd8, 16'h0003);
        repeat (400) @(negedge clk);

        // Flow-control pins
        wr_reg(4'd4, 16'h0002);
        check("R9 rts set", rts, 1'b1);
        @(negedge clk);
        cts = 1'b1;
        repeat (3) @(negedge clk);
        expect_reg(4'd6, 16'h0020, "R9 cts high");
        cts = 1'b0;
        repeat (3) @(negedge clk);
        expect_reg(4'd6, 16'h0000, "R9 cts low");
        wr_reg(4'd4, 16'h0000);
        check("R9 rts clear", rts, 1'b0);

        // Break
        mon_off = 1'b1;
        wr_reg(4'd3, 16'h0043);
        check("R10 break low", txd, 1'b0);
        repeat (50) @(negedge clk);
        check("R10 break held", txd, 1'b0);
        wr_reg(4'd3, 16'h0003);
        check("R10 break released", txd, 1'b1);
        repeat (5) @(negedge clk);
        mon_off = 1'b0;

        // Unsupported bits
        wr_reg(4'd1, 16'hFFFF);
        expect_reg(4'd1, 16'h000F, "R13 enable width");
        wr_reg(4'd1, 16'h0000);
        wr_reg(4'd3, 16'hFFBF);
        expect_reg(4'd3, 16'h0003, "R13 line control bits");
        wr_reg(4'd7, 16'hFFFF);
        expect_reg(4'd7, 16'h00FF, "R13 scratch width");
        wr_reg(4'd8, 16'hFFFF);
        expect_reg(4'd8, 16'h0003, "R13 enables width");
        wr_reg(4'd4, 16'hFFFF);
        expect_reg(4'd4, 16'h0002, "R13 modem control bits");
        wr_reg(4'd4, 16'h0000);
        wr_reg(4'd12, 16'hFFFF);
        expect_reg(4'd12, 16'h0000, "R13 unmapped index");
        expect_reg(4'd11, 16'h0000, "R13 unmapped index 11");
        wr_reg(4'd5, 16'hFFFF);
        expect_reg(4'd5, 16'h0060, "R13 status write ignored");
        wr_reg(4'd6, 16'hFFFF);
        expect_reg(4'd6, 16'h0000, "R13 modem status write ignored");

        repeat (20) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule